// File: doc/BRIEF.md
# Interrupt Priority Acceptance Sequencer

This block handles prioritized interrupts on the processor side of a small core. An external controller presents a 3-bit encoded request level. At each instruction-boundary strobe, and only then, the block compares that level against the interrupt mask held in the core's 16-bit status register. Levels 1 to 6 are level-sensitive and obey the mask. Level 7 cannot be masked and is taken only on its arrival.

When the block takes a request, it enters supervisor mode and turns tracing off. It then runs the exception entry over a simple request/ready memory port:

1. A tagged byte-wide acknowledge read, which returns the vector number.
2. Two 32-bit pushes that form the stack frame.
3. A 32-bit read of the handler address from the vector table.

The handler address is presented once as the branch target, together with the updated stack pointer. Instruction execution, the interrupt controller and memory lie outside the block. They appear only as ports: the boundary strobe, the interrupted PC, the stack pointer and the memory port.

Software writes the status register through a write port whenever no entry is in progress. The raised mask takes effect only after the old status value has been pushed.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o` and `branch_valid_o` are 0 and `sr_o` equals 16'h2700.
- R2: A level from 1 to 6 is taken only when all of these hold: `boundary_i` is high in a cycle where the block is idle, and the level is strictly greater than the mask in `sr_o[10:8]`. Level 0 is never taken. A level present while no boundary strobe occurs is not taken, and `busy_o` stays 0.
- R3: Level 7 is taken regardless of the mask, but only if the previously sampled level was below 7. A level 7 held across consecutive boundary samples is taken once. Sampling any level below 7 re-arms it.
- R4: In the cycle after acceptance, `sr_o` bit 13 (supervisor) is 1, `sr_o` bit 15 (trace) is 0 and the other bits are unchanged. This holds through the whole entry.
- R5: The first access is the acknowledge read: `mem_we_o`=0, `mem_wide_o`=0 (byte), `mem_tt_o`=2'b11, and `mem_addr_o` equals the level in bits 2:0 with all other bits zero. The vector number is `mem_rdata_i[7:0]`. Every other access uses `mem_tt_o`=2'b00 and `mem_wide_o`=1.
- R6: The second access writes the interrupted PC (`pc_i` sampled at acceptance) to the sampled `sp_i` minus 4.
- R7: The third access writes to `sp_i` minus 8 the word {8'h00, vector[7:0], saved status[15:0]}. The saved status is `sr_o` as it was before acceptance.
- R8: `sr_o[10:8]` keeps its old value until the third access completes. From the next cycle it equals the accepted level.
- R9: The fourth access reads address vector×4, with the vector in bits 9:2 and zeros elsewhere.
- R10: After the fourth access, `branch_valid_o` is 1 for exactly one cycle. In that cycle `branch_pc_o` holds the data read and `new_sp_o` equals `sp_i` minus 8. The block is idle in the next cycle.
- R11: While `mem_req_o` is 1 and `mem_rdy_i` is 0, the access stays requested and its address, direction and data do not change.
- R12: A status write (`sr_wr_i`) while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ipl_i | input | 3 | Encoded request level, 0 = none |
| boundary_i | input | 1 | Instruction-boundary sample strobe |
| pc_i | input | 32 | PC of the instruction being interrupted |
| sp_i | input | 32 | Current stack pointer |
| sr_wr_i | input | 1 | Software status register write |
| sr_wdata_i | input | 16 | Status value to write |
| sr_o | output | 16 | Status register |
| busy_o | output | 1 | Entry sequence in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write |
| mem_wide_o | output | 1 | 1 = 32-bit, 0 = byte |
| mem_tt_o | output | 2 | Transfer type, 2'b11 = acknowledge |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| mem_rdy_i | input | 1 | Access completes this cycle |
| branch_valid_o | output | 1 | Branch target valid pulse |
| branch_pc_o | output | 32 | Handler address |
| new_sp_o | output | 32 | Stack pointer after the frame |

## Verification
The hardest situation to reach from the ports is re-arming level 7. The edge memory changes only at boundary samples, so a level-7 entry must first leave the mask at 7. A second sample of level 7 must then be refused, a sample of level 6 must be refused by the mask, and a fresh level 7 must be taken.

The stimulus reaches this state by ordering the vector table so that its last row is a level-7 entry. Directed samples follow directly on the status that entry leaves behind. A software write injected mid-entry then shows that the frame and the mask ignore it.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W        = 3;
    localparam int SR_W         = 16;
    localparam int WORD_W       = 32;
    localparam int VEC_W        = 8;
    localparam int SR_MASK_LSB  = 8;
    localparam int SR_SUPV_BIT  = 13;
    localparam int SR_TRACE_BIT = 15;
    localparam int FRAME_STEP   = 4;

    localparam logic [LVL_W-1:0] LVL_TOP  = '1;
    localparam logic [1:0]       TT_DATA  = 2'b00;
    localparam logic [1:0]       TT_IACK  = 2'b11;
    localparam logic [SR_W-1:0]  SR_RESET = 16'h2700;

    typedef enum logic [2:0] {
        ST_IDLE, ST_IACK, ST_PUSH_PC, ST_PUSH_SR, ST_VFETCH, ST_JUMP
    } entry_st_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic              wide;
        logic [1:0]        tt;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [WORD_W-1:0] frame_word(
        input logic [VEC_W-1:0] vec, input logic [SR_W-1:0] sr);
        return {{(WORD_W-VEC_W-SR_W){1'b0}}, vec, sr};
    endfunction

    function automatic logic [WORD_W-1:0] table_addr(input logic [VEC_W-1:0] vec);
        return {{(WORD_W-VEC_W-2){1'b0}}, vec, 2'b00};
    endfunction
endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] mask_i,
    output logic             take_o
);
    logic top_seen_q;
    logic qualifies;

    always_comb begin
        if (lvl_i == LVL_TOP)
            qualifies = !top_seen_q;
        else
            qualifies = (lvl_i != '0) && (lvl_i > mask_i);
    end

    assign take_o = sample_i && qualifies;

    always_ff @(posedge clk) begin
        if (rst)
            top_seen_q <= 1'b0;
        else if (sample_i)
            top_seen_q <= (lvl_i == LVL_TOP);
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             sw_wr_i,
    input  logic [SR_W-1:0]  sw_data_i,
    input  logic             enter_i,
    input  logic             mask_load_i,
    input  logic [LVL_W-1:0] mask_lvl_i,
    output logic [SR_W-1:0]  sr_o
);
    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= SR_RESET;
        end else if (enter_i) begin
            sr_q[SR_SUPV_BIT]  <= 1'b1;
            sr_q[SR_TRACE_BIT] <= 1'b0;
        end else if (mask_load_i) begin
            sr_q[SR_MASK_LSB +: LVL_W] <= mask_lvl_i;
        end else if (sw_wr_i && !busy_i) begin
            sr_q <= sw_data_i;
        end
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic              rdy_i,
    output bus_cmd_t          cmd_o,
    output logic              busy_o,
    output logic              mask_load_o,
    output logic [LVL_W-1:0]  mask_lvl_o,
    output logic              jump_o,
    output logic [WORD_W-1:0] target_o,
    output logic [WORD_W-1:0] sp_o
);
    entry_st_e         st_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [WORD_W-1:0] pc_q, sp_q, target_q;
    logic [SR_W-1:0]   saved_sr_q;
    logic [VEC_W-1:0]  vec_q;
    logic [WORD_W-1:0] sp_dec;

    assign sp_dec = sp_q - WORD_W'(FRAME_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            lvl_q      <= '0;
            pc_q       <= '0;
            sp_q       <= '0;
            saved_sr_q <= '0;
            vec_q      <= '0;
            target_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (take_i) begin
                    lvl_q      <= lvl_i;
                    pc_q       <= pc_i;
                    sp_q       <= sp_i;
                    saved_sr_q <= sr_i;
                    st_q       <= ST_IACK;
                end
                ST_IACK: if (rdy_i) begin
                    vec_q <= rdata_i[VEC_W-1:0];
                    st_q  <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (rdy_i) begin
                    sp_q <= sp_dec;
                    st_q <= ST_PUSH_SR;
                end
                ST_PUSH_SR: if (rdy_i) begin
                    sp_q <= sp_dec;
                    st_q <= ST_VFETCH;
                end
                ST_VFETCH: if (rdy_i) begin
                    target_q <= rdata_i;
                    st_q     <= ST_JUMP;
                end
                ST_JUMP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o = '{req: 1'b0, we: 1'b0, wide: 1'b1, tt: TT_DATA, addr: '0, wdata: '0};
        unique case (st_q)
            ST_IACK: begin
                cmd_o.req  = 1'b1;
                cmd_o.wide = 1'b0;
                cmd_o.tt   = TT_IACK;
                cmd_o.addr = {{(WORD_W-LVL_W){1'b0}}, lvl_q};
            end
            ST_PUSH_PC: begin
                cmd_o.req   = 1'b1;
                cmd_o.we    = 1'b1;
                cmd_o.addr  = sp_dec;
                cmd_o.wdata = pc_q;
            end
            ST_PUSH_SR: begin
                cmd_o.req   = 1'b1;
                cmd_o.we    = 1'b1;
                cmd_o.addr  = sp_dec;
                cmd_o.wdata = frame_word(vec_q, saved_sr_q);
            end
            ST_VFETCH: begin
                cmd_o.req  = 1'b1;
                cmd_o.addr = table_addr(vec_q);
            end
            default: ;
        endcase
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign mask_load_o = (st_q == ST_PUSH_SR) && rdy_i;
    assign mask_lvl_o  = lvl_q;
    assign jump_o      = (st_q == ST_JUMP);
    assign target_o    = target_q;
    assign sp_o        = sp_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  ipl_i,
    input  logic              boundary_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic              sr_wr_i,
    input  logic [SR_W-1:0]   sr_wdata_i,
    output logic [SR_W-1:0]   sr_o,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_wide_o,
    output logic [1:0]        mem_tt_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic              branch_valid_o,
    output logic [WORD_W-1:0] branch_pc_o,
    output logic [WORD_W-1:0] new_sp_o
);
    logic             take, busy, mask_load;
    logic [LVL_W-1:0] mask_lvl;
    bus_cmd_t         cmd;

    irq_accept u_accept (
        .clk      (clk),
        .rst      (rst),
        .sample_i (boundary_i && !busy),
        .lvl_i    (ipl_i),
        .mask_i   (sr_o[SR_MASK_LSB +: LVL_W]),
        .take_o   (take)
    );

    irq_status_reg u_sr (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy),
        .sw_wr_i     (sr_wr_i),
        .sw_data_i   (sr_wdata_i),
        .enter_i     (take),
        .mask_load_i (mask_load),
        .mask_lvl_i  (mask_lvl),
        .sr_o        (sr_o)
    );

    irq_entry_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .lvl_i       (ipl_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .sr_i        (sr_o),
        .rdata_i     (mem_rdata_i),
        .rdy_i       (mem_rdy_i),
        .cmd_o       (cmd),
        .busy_o      (busy),
        .mask_load_o (mask_load),
        .mask_lvl_o  (mask_lvl),
        .jump_o      (branch_valid_o),
        .target_o    (branch_pc_o),
        .sp_o        (new_sp_o)
    );

    assign busy_o      = busy;
    assign mem_req_o   = cmd.req;
    assign mem_we_o    = cmd.we;
    assign mem_wide_o  = cmd.wide;
    assign mem_tt_o    = cmd.tt;
    assign mem_addr_o  = cmd.addr;
    assign mem_wdata_o = cmd.wdata;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  ipl_i,
    input logic        boundary_i,
    input logic        busy_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic        mem_wide_o,
    input logic [1:0]  mem_tt_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_rdy_i,
    input logic        branch_valid_o,
    input logic [15:0] sr_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req_o && !branch_valid_o && !busy_o));

    assert_start_on_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(boundary_i) && $past(ipl_i) != 3'd0));

    assert_mode_during_entry_R4: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (sr_o[13] && !sr_o[15]));

    assert_iack_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_tt_o == 2'b11) |-> (!mem_we_o && !mem_wide_o));

    assert_branch_single_R10: assert property (@(posedge clk) disable iff (rst)
        branch_valid_o |=> (!branch_valid_o && !busy_o));

    assert_hold_until_ready_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rdy_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_tt_o)));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ipl_i = 3'd0;
    logic        boundary_i = 1'b0;
    logic [31:0] pc_i = '0, sp_i = '0;
    logic        sr_wr_i = 1'b0;
    logic [15:0] sr_wdata_i = '0;
    logic [15:0] sr_o;
    logic        busy_o, mem_req_o, mem_we_o, mem_wide_o, branch_valid_o;
    logic [1:0]  mem_tt_o;
    logic [31:0] mem_addr_o, mem_wdata_o, branch_pc_o, new_sp_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_rdy_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_entry_seq dut (.*);

    // table row: {status value to write, level, expected take}
    localparam logic [19:0] TBL [10] = '{
        {16'h0000, 3'd0, 1'b0},
        {16'h0000, 3'd1, 1'b1},
        {16'h0300, 3'd3, 1'b0},
        {16'h0300, 3'd4, 1'b1},
        {16'h8600, 3'd6, 1'b0},
        {16'h8500, 3'd6, 1'b1},
        {16'h0700, 3'd7, 1'b1},
        {16'h0000, 3'd5, 1'b1},
        {16'h0200, 3'd2, 1'b0},
        {16'h0400, 3'd7, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_sr(input logic [15:0] v);
        @(negedge clk); sr_wr_i = 1'b1; sr_wdata_i = v;
        @(negedge clk); sr_wr_i = 1'b0;
    endtask

    task automatic sample(input logic [2:0] l);
        @(negedge clk); ipl_i = l; boundary_i = 1'b1;
        @(negedge clk); boundary_i = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        mem_rdata_i = d; mem_rdy_i = 1'b1;
        @(negedge clk); mem_rdy_i = 1'b0;
    endtask

    task automatic run_entry(input logic [2:0] lvl, input logic [15:0] osr,
                             input logic [31:0] pc, input logic [31:0] sp,
                             input logic [7:0] vec, input logic [31:0] hnd);
        logic [15:0] mid;
        mid = (osr | 16'h2000) & 16'h7fff;
        chk("R4 status after accept", {16'h0, sr_o}, {16'h0, mid});
        chk("R5 ack req/we/wide/tt", {27'h0, mem_req_o, mem_we_o, mem_wide_o, mem_tt_o},
            {27'h0, 1'b1, 1'b0, 1'b0, 2'b11});
        chk("R5 ack address", mem_addr_o, {29'h0, lvl});
        repeat (2) @(negedge clk);
        chk("R11 ack held without ready", {mem_req_o, mem_addr_o[30:0]}, {1'b1, 28'h0, lvl});
        respond({24'h5a5a5a, vec});
        chk("R6 pc push we/wide/tt", {28'h0, mem_we_o, mem_wide_o, mem_tt_o}, {28'h0, 1'b1, 1'b1, 2'b00});
        chk("R6 pc push address", mem_addr_o, sp - 32'd4);
        chk("R6 pc push data", mem_wdata_o, pc);
        respond(32'h0);
        chk("R7 status push address", mem_addr_o, sp - 32'd8);
        chk("R7 status push data", mem_wdata_o, {8'h00, vec, osr});
        chk("R8 mask unchanged before status push", {16'h0, sr_o}, {16'h0, mid});
        respond(32'h0);
        chk("R8 mask raised after status push", {16'h0, sr_o},
            {16'h0, (mid & 16'hf8ff) | {5'h0, lvl, 8'h00}});
        chk("R9 table read we/wide", {30'h0, mem_we_o, mem_wide_o}, {30'h0, 1'b0, 1'b1});
        chk("R9 table address", mem_addr_o, {22'h0, vec, 2'b00});
        respond(hnd);
        chk("R10 branch valid", {31'h0, branch_valid_o}, 32'h1);
        chk("R10 branch target", branch_pc_o, hnd);
        chk("R10 new stack pointer", new_sp_o, sp - 32'd8);
        @(negedge clk);
        chk("R10 pulse ends and idle", {30'h0, branch_valid_o, busy_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset outputs", {29'h0, busy_o, mem_req_o, branch_valid_o}, 32'h0);
        chk("R1 reset status", {16'h0, sr_o}, 32'h2700);

        for (int i = 0; i < 10; i++) begin
            logic [15:0] s;
            logic [2:0]  l;
            logic        t;
            {s, l, t} = TBL[i];
            write_sr(s);
            sample(3'd0);
            pc_i = 32'h2000_0000 + 32'(i * 16);
            sp_i = 32'h0040_0000 - 32'(i * 64);
            sample(l);
            chk(l == 3'd7 ? "R3 level 7 edge accept" : "R2 accept decision",
                {31'h0, busy_o}, {31'h0, t});
            if (t) run_entry(l, s, pc_i, sp_i, 8'(64 + i), 32'h1000_0000 + 32'(i * 256));
        end

        // mask is now 7 after the level-7 entry
        sample(3'd7);
        chk("R3 held level 7 not retaken", {31'h0, busy_o}, 32'h0);
        sample(3'd6);
        chk("R2 level 6 blocked by mask 7", {31'h0, busy_o}, 32'h0);
        pc_i = 32'h3000_0040; sp_i = 32'h0050_0000;
        sample(3'd7);
        chk("R3 level 7 re-armed", {31'h0, busy_o}, 32'h1);
        sr_wr_i = 1'b1; sr_wdata_i = 16'h0000;
        @(negedge clk); sr_wr_i = 1'b0;
        // R12: the write above must not alter status or frame
        run_entry(3'd7, 16'h2700, 32'h3000_0040, 32'h0050_0000, 8'hff, 32'hcafe_0000);

        write_sr(16'h0000);
        ipl_i = 3'd5;
        repeat (3) @(negedge clk);
        chk("R2 no accept without boundary", {31'h0, busy_o}, 32'h0);
        pc_i = 32'h4000_0000; sp_i = 32'h0060_0010;
        sample(3'd5);
        chk("R2 accept at boundary", {31'h0, busy_o}, 32'h1);
        run_entry(3'd5, 16'h0000, 32'h4000_0000, 32'h0060_0010, 8'h40, 32'h0000_8000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule